// File: doc/BRIEF.md
# Streaming Loop Accelerator Shell

This block runs one software inner loop in hardware. A processor writes a source address, a destination address and a trip count, then pulses an enable input and sleeps. For each iteration the shell reads one operand word from the source stream into a 32-bit input register. It reads one word from the destination stream into a 32-bit in/out register. A purely combinational function of the two registers then overwrites the in/out register, and the shell stores that register back to the same destination word. Both stream pointers then step forward by one word.

The combinational function is a replaceable slot. A parameter picks one of a few built-in placeholders, and the default is a 32-bit sum. Addressing is strictly sequential, and the trip count is fixed when the loop starts. When the last iteration has been written back, a done output rises and stays high until the next enable, so the sleeping processor can resume.

The memory port is a single request interface. Read data is returned on the clock edge that ends the request cycle. Writes take effect on the edge that ends the request cycle.

Top module: `loop_accel_shell`

## Requirements
- R1: After reset, `done` is 0 and `mem_req` is 0.
- R2: With the default fabric (sum modulo 2^32), a loop of N>0 iterations started from source byte address S and destination byte address D computes, for i = 0..N-1 in increasing order, word[D+4i] := word[S+4i] + word[D+4i]. Each iteration sees the results of earlier iterations, even when the two streams overlap.
- R3: Each iteration makes exactly three memory requests, in this order: a read of S+4i, a read of D+4i, then a write of D+4i (`mem_we`=1 only on the write). No request is made while the shell is idle or done.
- R4: `done` is first observed high exactly 5·N rising clock edges after the edge that samples `start`.
- R5: A trip count of 0 makes `done` high after the edge that samples `start`, with no memory request.
- R6: `done` stays high until the next `start`. A `start` with N>0 clears `done` at the edge that samples it.
- R7: A `start` pulse while a loop is running is ignored, including any new addresses or trip count presented with it. The running loop keeps its result and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle enable pulse from the processor |
| cfg_src | input | ADDR_W | Byte address of the first source operand |
| cfg_dst | input | ADDR_W | Byte address of the first in/out word |
| cfg_trip | input | CNT_W | Number of iterations |
| done | output | 1 | Loop complete; held until the next start |
| mem_req | output | 1 | Memory request valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data (in/out register) |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
Trip counts 0 through 7 are swept against four address layouts, and the final memory is compared word by word with an arithmetic model. Disjoint streams check plain element-wise combination. Identical streams separate the R0 read from the R1 read, because each result must be double the word. A destination one word above the source makes every iteration consume the previous result, which exposes any wrong ordering or stale operand. A destination one word below the source shows whether a write lands before a later read. Separate runs with a mid-loop enable carrying different settings, and with a long wait after completion, cover the ignore and hold behaviour.

// File: rtl/loop_accel_pkg.sv
package loop_accel_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD0  = 3'd1,
      ST_RD1  = 3'd2,
      ST_LD   = 3'd3,
      ST_CALC = 3'd4,
      ST_WR   = 3'd5,
      ST_DONE = 3'd6
   } lpa_state_t;

   // cycles spent per loop iteration: RD0, RD1, LD, CALC, WR
   localparam int LPA_BEATS = 5;

   // fabric placeholder selectors
   localparam int LPA_FN_ADD = 0;
   localparam int LPA_FN_XOR = 1;
   localparam int LPA_FN_ROX = 2;

endpackage

// File: rtl/lpa_ctrl.sv
module lpa_ctrl
   import loop_accel_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] trip,
   output lpa_state_t       state,
   output logic             busy,
   output logic             load,
   output logic             advance,
   output logic             done
);

   logic [CNT_W-1:0] rem;
   logic             trip_zero;
   logic             last_iter;

   assign trip_zero = (trip == '0);
   assign last_iter = (rem == CNT_W'(1));
   assign busy      = (state != ST_IDLE) && (state != ST_DONE);
   assign load      = start && !busy && !trip_zero;
   assign advance   = (state == ST_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         rem   <= '0;
         done  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  if (trip_zero) begin
                     state <= ST_DONE;
                     done  <= 1'b1;
                  end else begin
                     state <= ST_RD0;
                     rem   <= trip;
                     done  <= 1'b0;
                  end
               end
            end
            ST_RD0:  state <= ST_RD1;
            ST_RD1:  state <= ST_LD;
            ST_LD:   state <= ST_CALC;
            ST_CALC: state <= ST_WR;
            ST_WR: begin
               rem <= rem - CNT_W'(1);
               if (last_iter) begin
                  state <= ST_DONE;
                  done  <= 1'b1;
               end else begin
                  state <= ST_RD0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6: completion flag is sticky until the processor enables again
   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R5: zero trip count finishes at once without entering the loop
   p_zero_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && trip_zero) |=> (done && !busy));

   // R7: remaining count only moves on write-back, never from a new start
   p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state != ST_WR) |=> (rem == $past(rem)));

   // R4: write-back always follows the compute beat
   p_wr_after_calc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR) |-> ($past(state) == ST_CALC));

endmodule

// File: rtl/lpa_addr_gen.sv
module lpa_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int STRIDE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_ptr <= '0;
         dst_ptr <= '0;
      end else if (load) begin
         src_ptr <= src_base;
         dst_ptr <= dst_base;
      end else if (advance) begin
         src_ptr <= src_ptr + STEP;
         dst_ptr <= dst_ptr + STEP;
      end
   end

   // R2: both streams step by one word after each iteration
   p_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> (src_ptr == $past(src_ptr) + STEP &&
                              dst_ptr == $past(dst_ptr) + STEP));

endmodule

// File: rtl/lpa_datapath.sv
module lpa_datapath
   import loop_accel_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int FUNC_SEL = LPA_FN_ADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_r0,
   input  logic              cap_r1,
   input  logic              compute,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] r1_q
);

   logic [DATA_W-1:0] r0_q;
   logic [DATA_W-1:0] fab_out;

   generate
      if (FUNC_SEL == LPA_FN_ADD) begin : g_fab_add
         assign fab_out = r0_q + r1_q;
      end else if (FUNC_SEL == LPA_FN_XOR) begin : g_fab_xor
         assign fab_out = r0_q ^ r1_q;
      end else if (FUNC_SEL == LPA_FN_ROX) begin : g_fab_rox
         assign fab_out = {r1_q[DATA_W-2:0], r1_q[DATA_W-1]} ^ r0_q;
      end else begin : g_fab_bad
         $error("lpa_datapath: FUNC_SEL out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r0_q <= '0;
      end else if (cap_r0) begin
         r0_q <= rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r1_q <= '0;
      end else if (cap_r1) begin
         r1_q <= rdata;
      end else if (compute) begin
         r1_q <= fab_out;
      end
   end

   // R2: in/out register is quiet outside its load and compute beats
   p_r1_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_r1 || compute) |=> $stable(r1_q));

endmodule

// File: rtl/loop_accel_shell.sv
module loop_accel_shell
   import loop_accel_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 8,
   parameter int FUNC_SEL = LPA_FN_ADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [CNT_W-1:0]  cfg_trip,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int BYTES = DATA_W / 8;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_chk_dw
         $error("loop_accel_shell: DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < 4) begin : g_chk_aw
         $error("loop_accel_shell: ADDR_W too small");
      end
      if (CNT_W < 1) begin : g_chk_cw
         $error("loop_accel_shell: CNT_W must be positive");
      end
   endgenerate

   lpa_state_t        state;
   logic              busy;
   logic              load;
   logic              advance;
   logic [ADDR_W-1:0] src_ptr;
   logic [ADDR_W-1:0] dst_ptr;

   lpa_ctrl #(
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .trip    (cfg_trip),
      .state   (state),
      .busy    (busy),
      .load    (load),
      .advance (advance),
      .done    (done)
   );

   lpa_addr_gen #(
      .ADDR_W (ADDR_W),
      .STRIDE (BYTES)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .advance  (advance),
      .src_base (cfg_src),
      .dst_base (cfg_dst),
      .src_ptr  (src_ptr),
      .dst_ptr  (dst_ptr)
   );

   lpa_datapath #(
      .DATA_W   (DATA_W),
      .FUNC_SEL (FUNC_SEL)
   ) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_r0  (state == ST_RD1),
      .cap_r1  (state == ST_LD),
      .compute (state == ST_CALC),
      .rdata   (mem_rdata),
      .r1_q    (mem_wdata)
   );

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = '0;
      unique case (state)
         ST_RD0: begin
            mem_req  = 1'b1;
            mem_addr = src_ptr;
         end
         ST_RD1: begin
            mem_req  = 1'b1;
            mem_addr = dst_ptr;
         end
         ST_WR: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = dst_ptr;
         end
         default: ;
      endcase
   end

   // R3: no memory traffic outside a running loop
   p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R3: write strobe only accompanies a request
   p_we_in_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   // R1: quiet outputs straight after reset release
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!done && !mem_req));

endmodule

// File: tb/loop_accel_shell_tb.sv
module loop_accel_shell_tb;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int CW = 8;
   localparam int BEATS = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [AW-1:0] cfg_src;
   logic [AW-1:0] cfg_dst;
   logic [CW-1:0] cfg_trip;
   logic          done;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   int vec_n = 0;
   int bad_n = 0;

   logic [31:0] mem  [256];
   logic [31:0] expm [256];
   logic        fill = 1'b0;
   int          seed = 0;
   int          acc_n = 0;
   int          ord_err = 0;
   int          exp_s = 0;
   int          exp_d = 0;

   always #5 clk = ~clk;

   loop_accel_shell #(
      .ADDR_W (AW),
      .DATA_W (DW),
      .CNT_W  (CW)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_src   (cfg_src),
      .cfg_dst   (cfg_dst),
      .cfg_trip  (cfg_trip),
      .done      (done),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   function automatic logic [31:0] pat(int k, int s);
      return (32'(k) * 32'h9E3779B9) ^ (32'(s) * 32'h01010101) ^ 32'h5A5A0000;
   endfunction

   // memory model with access-order monitor
   always @(posedge clk) begin : mem_model
      int it;
      int ph;
      int ew;
      if (fill) begin
         for (int k = 0; k < 256; k++) mem[k] <= pat(k, seed);
         acc_n   <= 0;
         ord_err <= 0;
      end else if (mem_req) begin
         it = acc_n / 3;
         ph = acc_n % 3;
         ew = (ph == 0) ? exp_s + it : exp_d + it;
         if (mem_addr[9:2] != 8'(ew) || mem_addr[1:0] != 2'b00 ||
             mem_we != (ph == 2))
            ord_err <= ord_err + 1;
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[9:2]];
         acc_n <= acc_n + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      vec_n++;
      if (!ok) begin
         bad_n++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic prep(input int n, input int s, input int d, input int sd);
      seed = sd;
      fill = 1'b1;
      @(posedge clk);
      #1 fill = 1'b0;
      for (int k = 0; k < 256; k++) expm[k] = pat(k, sd);
      for (int i = 0; i < n; i++)
         expm[d/4 + i] = expm[s/4 + i] + expm[d/4 + i];
      exp_s    = s / 4;
      exp_d    = d / 4;
      cfg_src  = AW'(s);
      cfg_dst  = AW'(d);
      cfg_trip = CW'(n);
   endtask

   task automatic verify(input int n, input int cyc, input string tag);
      int mism;
      int first;
      mism  = 0;
      first = -1;
      chk(cyc == BEATS * n, {tag, " R4/R5 latency"}, cyc, BEATS * n);
      for (int k = 0; k < 256; k++)
         if (mem[k] !== expm[k]) begin
            mism++;
            if (first < 0) first = k;
         end
      chk(mism == 0, {tag, " R2 memory"},
          (first < 0) ? 0 : longint'(mem[first]), (first < 0) ? 0 : longint'(expm[first]));
      chk(acc_n == 3 * n, {tag, " R3/R5 access count"}, acc_n, 3 * n);
      chk(ord_err == 0, {tag, " R3 access order"}, ord_err, 0);
   endtask

   task automatic run(input int n, input int s, input int d, input int sd);
      int cyc;
      prep(n, s, d, sd);
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      cyc = 0;
      if (n > 0) chk(done == 1'b0, "R6 done cleared by start", done, 0);
      while (!done && cyc < 200) begin
         @(posedge clk);
         #1 cyc++;
      end
      verify(n, cyc, $sformatf("n=%0d s=%0d d=%0d", n, s, d));
   endtask

   initial begin : watchdog
      #1_500_000;
      bad_n++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
   end

   initial begin : main
      int srcs [4];
      int dsts [4];
      int cyc;
      srcs = '{32'h040, 32'h100, 32'h080, 32'h184};
      dsts = '{32'h200, 32'h100, 32'h084, 32'h180};
      rst_n    = 1'b0;
      start    = 1'b0;
      cfg_src  = '0;
      cfg_dst  = '0;
      cfg_trip = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(done == 1'b0, "R1 reset done", done, 0);
      chk(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);

      // sweep: trip count x address layout
      for (int p = 0; p < 4; p++)
         for (int n = 0; n < 8; n++)
            run(n, srcs[p], dsts[p], p * 8 + n + 1);

      // R6: done holds through idle cycles
      repeat (10) @(posedge clk);
      #1 chk(done == 1'b1, "R6 done held", done, 1);

      // R7: start while busy, with different settings, is ignored
      prep(3, 32'h040, 32'h200, 77);
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      cyc = 0;
      repeat (6) begin
         @(posedge clk);
         #1 cyc++;
      end
      cfg_src  = AW'(32'h300);
      cfg_dst  = AW'(32'h020);
      cfg_trip = CW'(6);
      start    = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      cyc++;
      while (!done && cyc < 200) begin
         @(posedge clk);
         #1 cyc++;
      end
      verify(3, cyc, "R7 start while busy");

      // R5: zero trip from done state keeps done high, no traffic
      run(0, 32'h040, 32'h200, 99);

      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
   end

endmodule